// File: doc/BRIEF.md
# Sequential Multiply-Accumulate Unit

This unit carries out the whole 32x32 multiply family of a general-purpose integer core. It covers a short form that keeps one word of product (optionally plus a one-word addend) and a long form that keeps a two-word product (optionally plus a two-word addend). Both signed and unsigned long products are supported. The result comes out several cycles after a start request. The long accumulate folds the carry out of the low-word addition into the high word, so that a double-word running sum can be kept in two registers.

The caller presents both factors, the addend words, and four mode bits on a cycle where the unit is idle, and pulses `start`. The unit captures everything on that edge. It then walks through the sign-extended multiplier one digit per cycle. A digit is one bit or a radix-4 pair, picked by a parameter. The unit then applies the addend and raises `done` for one cycle with the result words and the updated negative and zero flags. The flags change only when the flag-write bit was set. Carry and overflow flags are not part of the block's outputs and are never produced.

Top module: `mac_seq_unit`

## Requirements
- R1: With `long_mode`=0 and `acc_en`=0, `res_lo` is bits [W-1:0] of `mul_a`*`mul_b`, identical for `signed_mode` 0 and 1, and `res_hi` is 0.
- R2: With `long_mode`=0 and `acc_en`=1, `res_lo` is bits [W-1:0] of `mul_a`*`mul_b` + `acc_lo`, and `res_hi` is 0. `acc_hi` has no effect.
- R3: With `long_mode`=1 and `acc_en`=0, {`res_hi`,`res_lo`} is the full 2W-bit product. Both factors are taken as two's complement when `signed_mode`=1 and as unsigned when it is 0.
- R4: With `long_mode`=1 and `acc_en`=1, {`res_hi`,`res_lo`} is the product plus {`acc_hi`,`acc_lo`} modulo 2^(2W). The carry out of the low-word sum is added into the high word.
- R5: When `flag_wr`=1, `flag_n` after completion is result bit W-1 in the short form and bit 2W-1 (top bit of `res_hi`) in the long form.
- R6: When `flag_wr`=1, `flag_z` after completion is 1 only if the whole result is zero: `res_lo` alone in the short form, both words in the long form.
- R7: When `flag_wr`=0, `flag_n` and `flag_z` keep the values they had before the operation.
- R8: A start seen while idle is accepted, and `busy` is 1 from the next cycle. `done` is a one-cycle pulse exactly STEPS+1 clock edges after the accepting edge, where STEPS = 2W/DIGIT_BITS. `busy` is 0 in the `done` cycle.
- R9: A `start` raised while `busy` is 1 is ignored. The running operation finishes on its original schedule with its original operands, even if the inputs change.
- R10: After reset, `busy`, `done`, `res_lo`, `res_hi`, `flag_n` and `flag_z` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| mul_a | input | W | First factor |
| mul_b | input | W | Second factor |
| acc_lo | input | W | Addend low word (sole addend in short form) |
| acc_hi | input | W | Addend high word (long form only) |
| signed_mode | input | 1 | 1 = two's-complement factors |
| long_mode | input | 1 | 1 = two-word result |
| acc_en | input | 1 | 1 = add the addend to the product |
| flag_wr | input | 1 | 1 = update flag_n and flag_z |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res_lo | output | W | Result low word |
| res_hi | output | W | Result high word (0 in short form) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the unit with W=32 and DIGIT_BITS=2. This selects the radix-4 iteration variant, so the latency check expects 33 edges from acceptance to `done`. Full-width factors reach the extreme carries: the largest unsigned square plus an all-ones addend, and the most negative signed value squared. At this width, 64-bit bench arithmetic gives exact reference values for every mode.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } mac_state_t;

   typedef struct packed {
      logic is_signed;
      logic is_long;
      logic add_en;
      logic flag_en;
   } mac_cfg_t;

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep #(
   parameter int W = 32
) (
   input  logic           is_signed,
   input  logic [W-1:0]   in_a,
   input  logic [W-1:0]   in_b,
   output logic [2*W-1:0] ext_a,
   output logic [2*W-1:0] ext_b
);
   localparam int W2 = 2 * W;

   logic fill_a;
   logic fill_b;

   always_comb begin
      fill_a = is_signed & in_a[W-1];
      fill_b = is_signed & in_b[W-1];
      ext_a  = {{W{fill_a}}, in_a};
      ext_b  = {{W{fill_b}}, in_b};
   end

   if (W2 != 2 * W) begin : g_bad_w2
      $error("mac_operand_prep: width mismatch");
   end
endmodule

// File: rtl/mac_iter_core.sv
module mac_iter_core #(
   parameter int W2         = 64,
   parameter int DIGIT_BITS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [W2-1:0] mcand_in,
   input  logic [W2-1:0] mplier_in,
   output logic [W2-1:0] prod
);
   logic [W2-1:0] mcand_q;
   logic [W2-1:0] mplier_q;
   logic [W2-1:0] prod_q;
   logic [W2-1:0] addend;

   if (DIGIT_BITS != 1 && DIGIT_BITS != 2) begin : g_bad_digit
      $error("mac_iter_core: DIGIT_BITS must be 1 or 2");
   end

   if (DIGIT_BITS == 1) begin : g_radix2
      always_comb begin
         addend = mplier_q[0] ? mcand_q : '0;
      end
   end else begin : g_radix4
      logic [W2-1:0] single_m;
      logic [W2-1:0] double_m;
      always_comb begin
         single_m = mplier_q[0] ? mcand_q : '0;
         double_m = mplier_q[1] ? (mcand_q << 1) : '0;
         addend   = single_m + double_m;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         prod_q   <= '0;
      end else if (load) begin
         mcand_q  <= mcand_in;
         mplier_q <= mplier_in;
         prod_q   <= '0;
      end else if (step) begin
         prod_q   <= prod_q + addend;
         mcand_q  <= mcand_q << DIGIT_BITS;
         mplier_q <= mplier_q >> DIGIT_BITS;
      end
   end

   assign prod = prod_q;

   // R8: every operation starts from an empty partial product
   assert_fresh_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (prod_q == '0));

   // R8: with nothing to step, the partial product holds still
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(prod_q));
endmodule

// File: rtl/mac_acc_merge.sv
module mac_acc_merge #(
   parameter int W = 32
) (
   input  logic [2*W-1:0] prod,
   input  logic [W-1:0]   add_lo,
   input  logic [W-1:0]   add_hi,
   input  logic           is_long,
   input  logic           add_en,
   output logic [W-1:0]   sum_lo,
   output logic [W-1:0]   sum_hi,
   output logic           neg,
   output logic           zero
);
   logic [W:0]   lo_wide;
   logic [W-1:0] eff_lo;
   logic [W-1:0] eff_hi;
   logic         lo_carry;
   logic [W-1:0] hi_raw;

   always_comb begin
      eff_lo   = add_en ? add_lo : '0;
      eff_hi   = (add_en && is_long) ? add_hi : '0;
      lo_wide  = {1'b0, prod[W-1:0]} + {1'b0, eff_lo};
      lo_carry = lo_wide[W];
      hi_raw   = prod[2*W-1:W] + eff_hi + {{(W-1){1'b0}}, lo_carry};
      sum_lo   = lo_wide[W-1:0];
      sum_hi   = is_long ? hi_raw : '0;
      neg      = is_long ? hi_raw[W-1] : lo_wide[W-1];
      zero     = (sum_lo == '0) && (sum_hi == '0);
   end
endmodule

// File: rtl/mac_seq_unit.sv
module mac_seq_unit #(
   parameter int W          = 32,
   parameter int DIGIT_BITS = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] mul_a,
   input  logic [W-1:0] mul_b,
   input  logic [W-1:0] acc_lo,
   input  logic [W-1:0] acc_hi,
   input  logic         signed_mode,
   input  logic         long_mode,
   input  logic         acc_en,
   input  logic         flag_wr,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] res_lo,
   output logic [W-1:0] res_hi,
   output logic         flag_n,
   output logic         flag_z
);
   import mac_pkg::*;

   localparam int W2    = 2 * W;
   localparam int STEPS = W2 / DIGIT_BITS;
   localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

   if (W < 2) begin : g_bad_w
      $error("mac_seq_unit: W must be at least 2");
   end
   if (W2 % DIGIT_BITS != 0) begin : g_bad_split
      $error("mac_seq_unit: 2*W must be a multiple of DIGIT_BITS");
   end

   mac_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   mac_cfg_t         cfg_q;
   logic [W-1:0]     add_lo_q;
   logic [W-1:0]     add_hi_q;
   logic [W-1:0]     res_lo_q;
   logic [W-1:0]     res_hi_q;
   logic             n_q;
   logic             z_q;
   logic             done_q;

   logic             accept;
   logic [W2-1:0]    ext_a;
   logic [W2-1:0]    ext_b;
   logic [W2-1:0]    prod;
   logic [W-1:0]     m_lo;
   logic [W-1:0]     m_hi;
   logic             m_neg;
   logic             m_zero;

   assign accept = (state_q == ST_IDLE) && start;

   mac_operand_prep #(.W(W)) i_prep (
      .is_signed (signed_mode),
      .in_a      (mul_a),
      .in_b      (mul_b),
      .ext_a     (ext_a),
      .ext_b     (ext_b)
   );

   mac_iter_core #(.W2(W2), .DIGIT_BITS(DIGIT_BITS)) i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .step      (state_q == ST_RUN),
      .mcand_in  (ext_a),
      .mplier_in (ext_b),
      .prod      (prod)
   );

   mac_acc_merge #(.W(W)) i_merge (
      .prod    (prod),
      .add_lo  (add_lo_q),
      .add_hi  (add_hi_q),
      .is_long (cfg_q.is_long),
      .add_en  (cfg_q.add_en),
      .sum_lo  (m_lo),
      .sum_hi  (m_hi),
      .neg     (m_neg),
      .zero    (m_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         cfg_q    <= '0;
         add_lo_q <= '0;
         add_hi_q <= '0;
         res_lo_q <= '0;
         res_hi_q <= '0;
         n_q      <= 1'b0;
         z_q      <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q  <= ST_RUN;
                  cnt_q    <= CNT_W'(STEPS - 1);
                  cfg_q    <= '{is_signed: signed_mode, is_long: long_mode,
                                add_en: acc_en, flag_en: flag_wr};
                  add_lo_q <= acc_lo;
                  add_hi_q <= acc_hi;
               end
            end
            ST_RUN: begin
               if (cnt_q == '0) state_q <= ST_FIN;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            ST_FIN: begin
               state_q  <= ST_IDLE;
               done_q   <= 1'b1;
               res_lo_q <= m_lo;
               res_hi_q <= m_hi;
               if (cfg_q.flag_en) begin
                  n_q <= m_neg;
                  z_q <= m_zero;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state_q != ST_IDLE);
   assign done   = done_q;
   assign res_lo = res_lo_q;
   assign res_hi = res_hi_q;
   assign flag_n = n_q;
   assign flag_z = z_q;

   // R8: an accepted start makes the unit busy on the next cycle
   assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   // R8: completion is a single-cycle pulse and the unit is idle then
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9: a start during a run leaves the captured operation untouched
   assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(cfg_q) && $stable(add_lo_q) && $stable(add_hi_q)));

   // R1: short forms never report a high word
   assert_short_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cfg_q.is_long) |-> (res_hi == '0));

   // R5: negative flag follows the top bit of the form's result
   assert_neg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cfg_q.flag_en) |-> (flag_n == (cfg_q.is_long ? res_hi[W-1] : res_lo[W-1])));

   // R6: zero flag set only for an all-zero result
   assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cfg_q.flag_en) |-> (flag_z == ((res_lo == '0) && (res_hi == '0))));

   // R7: flags hold when the operation does not write them
   assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cfg_q.flag_en) |-> ($stable(flag_n) && $stable(flag_z)));
endmodule

// File: tb/test_mac_seq_unit.sv
module test_mac_seq_unit;
   localparam int W      = 32;
   localparam int DIGITS = 2;
   localparam int STEPS  = (2 * W) / DIGITS;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] mul_a = '0, mul_b = '0, acc_lo = '0, acc_hi = '0;
   logic         signed_mode = 1'b0, long_mode = 1'b0, acc_en = 1'b0, flag_wr = 1'b0;
   logic         busy, done, flag_n, flag_z;
   logic [W-1:0] res_lo, res_hi;

   int checks = 0;
   int bad    = 0;
   logic exp_n = 1'b0;
   logic exp_z = 1'b0;

   always #2 clk = ~clk;

   mac_seq_unit #(.W(W), .DIGIT_BITS(DIGITS)) i_mac_seq_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .mul_a(mul_a), .mul_b(mul_b),
      .acc_lo(acc_lo), .acc_hi(acc_hi), .signed_mode(signed_mode),
      .long_mode(long_mode), .acc_en(acc_en), .flag_wr(flag_wr),
      .busy(busy), .done(done), .res_lo(res_lo), .res_hi(res_hi),
      .flag_n(flag_n), .flag_z(flag_z)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_sum(input logic [31:0] a, input logic [31:0] b,
                                           input logic [31:0] lo, input logic [31:0] hi,
                                           input logic sg, input logic lg, input logic ac);
      logic [63:0] ea, eb, p, s;
      ea = sg ? {{32{a[31]}}, a} : {32'b0, a};
      eb = sg ? {{32{b[31]}}, b} : {32'b0, b};
      p  = ea * eb;
      s  = p + (ac ? (lg ? {hi, lo} : {32'b0, lo}) : 64'b0);
      if (!lg) s[63:32] = '0;
      return s;
   endfunction

   task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] lo, input logic [31:0] hi,
                         input logic sg, input logic lg, input logic ac,
                         input logic fw, input bit poke);
      logic [63:0] exp;
      int cyc;
      string tag;
      tag = lg ? (ac ? "R4" : "R3") : (ac ? "R2" : "R1");
      exp = ref_sum(a, b, lo, hi, sg, lg, ac);
      @(negedge clk);
      mul_a = a; mul_b = b; acc_lo = lo; acc_hi = hi;
      signed_mode = sg; long_mode = lg; acc_en = ac; flag_wr = fw;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      chk("R8 busy after accept", {63'b0, busy}, 64'd1);
      cyc = 0;
      while (cyc < 200) begin
         @(posedge clk); #1;
         cyc++;
         if (done) break;
         if (poke && cyc == 3) begin
            mul_a = ~a; mul_b = b ^ 32'h5A5A_A5A5; acc_lo = ~lo; acc_hi = ~hi;
            long_mode = ~lg; acc_en = ~ac; flag_wr = ~fw; start = 1'b1;
         end
         if (poke && cyc == 4) start = 1'b0;
      end
      chk("R8 latency", 64'(cyc), 64'(STEPS + 1));
      chk("R8 busy low at done", {63'b0, busy}, 64'd0);
      chk(poke ? "R9 result after ignored start" : tag, {res_hi, res_lo}, exp);
      if (fw) begin
         exp_n = lg ? exp[63] : exp[31];
         exp_z = (exp == 64'b0);
      end
      chk(fw ? "R5 flag_n" : "R7 flag_n held", {63'b0, flag_n}, {63'b0, exp_n});
      chk(fw ? "R6 flag_z" : "R7 flag_z held", {63'b0, flag_z}, {63'b0, exp_z});
      @(posedge clk); #1;
      chk("R8 done one cycle", {63'b0, done}, 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd1234);
      repeat (3) @(posedge clk);
      #1;
      chk("R10 busy", {63'b0, busy}, 64'd0);
      chk("R10 done", {63'b0, done}, 64'd0);
      chk("R10 result", {res_hi, res_lo}, 64'd0);
      chk("R10 flags", {62'b0, flag_n, flag_z}, 64'd0);
      @(negedge clk); rst_n = 1'b1;

      // directed corners
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R1 unsigned view
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); // R1 same low word signed
      run_op(32'h0001_0000, 32'h0001_0000, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R6 short zero
      run_op(32'd7, 32'd9, 32'hFFFF_FFC1, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // R2 wrap to zero
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0); // R3 -1*-1
      run_op(32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0); // R3 min*min
      run_op(32'h8000_0000, 32'h0000_0003, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0); // R5 negative long
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // R4 carry
      run_op(32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // R4 low carry into high
      run_op(32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R6 long zero
      run_op(32'h0000_0003, 32'h0000_0005, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R7 hold zero flag
      run_op(32'h1234_5678, 32'h0BAD_F00D, 32'h11, 32'h22, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1); // R9 poke

      // constrained random
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a, b, lo, hi;
         logic [3:0]  m;
         a = $urandom(); b = $urandom(); lo = $urandom(); hi = $urandom(); m = 4'($urandom());
         if (i % 10 == 0) a = {$urandom_range(1, 0) == 1 ? 32'h8000_0000 : 32'hFFFF_FFFF};
         if (i % 13 == 0) b = 32'h0;
         run_op(a, b, lo, hi, m[0], m[1], m[2], m[3], (i % 25 == 7));
      end

      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule